// File: doc/BRIEF.md
# Differential Level-Shift Command Encoder

This block sits between ground-referenced control logic and a floating high-side gate driver. It turns each change of the high-side command into a short pulse code on one of two separate channels. A rising command becomes a pair of pulses on the on-channel. A falling command becomes one pulse on the off-channel. Because the code is split across two channels, a common-mode disturbance that hits both channels at once cannot be read as a valid command on the far side.

The low-side command drives the low-side gate enable through a register delay. That delay is exactly as long as the latency from a high-side edge to the first pulse, so both sides of a half bridge respond at the same time. A supply-good flag gates everything: while it is low, all three outputs are held inactive. When it returns, the block sends the code for the current high-side level again, so the floating driver picks up the right state. The command inputs are expected to be synchronised already.

Top module: `level_shift_encoder`

## Requirements
- R1: A rising edge of `hs_cmd` produces exactly two `on_pulse` pulses. Each is PULSE_W cycles high, and they are separated by GAP_W low cycles. The first pulse starts START_LAT cycles after the new level is first sampled on a clock edge.
- R2: A falling edge of `hs_cmd` produces exactly one `off_pulse` pulse, PULSE_W cycles high. It starts START_LAT cycles after the new level is first sampled.
- R3: `on_pulse` and `off_pulse` are never high in the same cycle.
- R4: A new `hs_cmd` edge that arrives while a sequence is running aborts that sequence. The sequence for the new edge then starts with the normal START_LAT latency, and the aborted channel stays low from then on.
- R5: While `supply_ok` is low, `on_pulse`, `off_pulse` and `ls_gate` are low in the same cycle. This holds whatever the command inputs do.
- R6: On the first clock edge that samples `supply_ok` high after it was low (this includes the first edge after reset), a sequence starts for the current high-side level. A high level gives an on-pair and a low level gives a single off-pulse. The first pulse is visible one cycle after that edge.
- R7: `ls_gate` follows `ls_cmd` with a delay of START_LAT cycles. This equals the edge-to-pulse latency of R1 and R2, and it has no effect on either channel output.
- R8: An asserted `rst_n` (active low, asynchronous) drives all outputs low at once and clears any running sequence.
- R9: While `hs_cmd` is unchanged and `supply_ok` stays high, no pulse appears once the previous sequence has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_cmd | input | 1 | High-side command, active high, already synchronised |
| ls_cmd | input | 1 | Low-side command, active high, already synchronised |
| supply_ok | input | 1 | Supply-good flag; low forces all outputs inactive |
| on_pulse | output | 1 | On-channel pulse output (pair of pulses = turn on) |
| off_pulse | output | 1 | Off-channel pulse output (single pulse = turn off) |
| ls_gate | output | 1 | Delayed low-side gate enable |

## Verification
The high-side encoder is driven by several patterns, and each one isolates a different behaviour:
- Plain rising and falling edges separate the two-pulse code from the one-pulse code.
- A repeated level tells real edge detection apart from reacting to the level itself.
- An edge that arrives inside a pulse, and another inside the inter-pulse gap, show whether an old sequence is really abandoned.

Supply drops, with command toggles while the supply is down, followed by recovery at each high-side level, show the forcing and the resynchronisation. A low-side change made on the same edge as a high-side change shows whether both paths share the same latency.

// File: rtl/level_shift_encoder.sv
`timescale 1ns/1ps
module level_shift_encoder #(
  parameter int PULSE_W   = 8,
  parameter int GAP_W     = 8,
  parameter int START_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_cmd,
  input  logic ls_cmd,
  input  logic supply_ok,
  output logic on_pulse,
  output logic off_pulse,
  output logic ls_gate
);
  localparam int HS_STAGES = START_LAT - 1;
  localparam int CNT_MAX   = (PULSE_W > GAP_W) ? PULSE_W : GAP_W;
  localparam int CW        = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ON1, S_GAP, S_ON2, S_OFF} seq_t;

  logic [HS_STAGES-1:0] hs_dly;
  logic [START_LAT-1:0] ls_dly;
  logic                 hs_prev, sup_q;
  seq_t                 st;
  logic [CW-1:0]        cnt;

  wire hs_lvl = hs_dly[HS_STAGES-1];
  wire start  = supply_ok && ((hs_lvl != hs_prev) || !sup_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_dly  <= '0;
      ls_dly  <= '0;
      hs_prev <= 1'b0;
      sup_q   <= 1'b0;
    end else begin
      hs_dly[0] <= hs_cmd;
      for (int i = 1; i < HS_STAGES; i++) hs_dly[i] <= hs_dly[i-1];
      ls_dly[0] <= ls_cmd;
      for (int i = 1; i < START_LAT; i++) ls_dly[i] <= ls_dly[i-1];
      hs_prev <= hs_lvl;
      sup_q   <= supply_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (!supply_ok) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (start) begin
      st  <= hs_lvl ? S_ON1 : S_OFF;
      cnt <= CW'(PULSE_W - 1);
    end else begin
      case (st)
        S_ON1:
          if (cnt == '0) begin
            st  <= S_GAP;
            cnt <= CW'(GAP_W - 1);
          end else cnt <= cnt - 1'b1;
        S_GAP:
          if (cnt == '0) begin
            st  <= S_ON2;
            cnt <= CW'(PULSE_W - 1);
          end else cnt <= cnt - 1'b1;
        S_ON2, S_OFF:
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign on_pulse  = supply_ok && (st == S_ON1 || st == S_ON2);
  assign off_pulse = supply_ok && (st == S_OFF);
  assign ls_gate   = supply_ok && ls_dly[START_LAT-1];
endmodule

// File: rtl/level_shift_encoder_chk.sv
`timescale 1ns/1ps
module level_shift_encoder_chk #(
  parameter int PULSE_W   = 8,
  parameter int GAP_W     = 8,
  parameter int START_LAT = 2
) (
  input logic clk,
  input logic rst_n,
  input logic hs_cmd,
  input logic ls_cmd,
  input logic supply_ok,
  input logic on_pulse,
  input logic off_pulse,
  input logic ls_gate
);
  localparam int QUIET = START_LAT + 2 * PULSE_W + GAP_W + 1;

  int   on_run, off_run, lcnt, quiet;
  logic ls_p, hs_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_run <= 0; off_run <= 0; lcnt <= 0; quiet <= 0;
      ls_p <= 1'b0; hs_p <= 1'b0;
    end else begin
      on_run  <= on_pulse  ? on_run + 1  : 0;
      off_run <= off_pulse ? off_run + 1 : 0;
      ls_p <= ls_cmd;
      hs_p <= hs_cmd;
      if (ls_cmd != ls_p) lcnt <= 0;
      else if (lcnt < START_LAT) lcnt <= lcnt + 1;
      if (!supply_ok || hs_cmd != hs_p) quiet <= 0;
      else if (quiet < QUIET) quiet <= quiet + 1;
    end
  end

  AST_CHANNEL_MUTEX: assert property (@(posedge clk) disable iff (!rst_n)
    !(on_pulse && off_pulse)); // R3
  AST_SUPPLY_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (!on_pulse && !off_pulse && !ls_gate)); // R5
  AST_ON_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    on_run <= PULSE_W); // R1
  AST_OFF_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(off_pulse) && supply_ok && !on_pulse) |-> off_run == PULSE_W); // R2
  AST_LS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && ls_cmd == ls_p && lcnt >= START_LAT - 1) |-> ls_gate == ls_cmd); // R7
  AST_QUIET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet >= QUIET) |-> (!on_pulse && !off_pulse)); // R9
endmodule

bind level_shift_encoder level_shift_encoder_chk #(
  .PULSE_W(PULSE_W), .GAP_W(GAP_W), .START_LAT(START_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_cmd(hs_cmd), .ls_cmd(ls_cmd),
  .supply_ok(supply_ok), .on_pulse(on_pulse), .off_pulse(off_pulse),
  .ls_gate(ls_gate)
);

// File: tb/level_shift_encoder_test.sv
`timescale 1ns/1ps
module level_shift_encoder_test;
  localparam int PW  = 8;
  localparam int GW  = 8;
  localparam int LAT = 2;
  // {hs level, kind}: kind 0 = no pulses, 1 = on pair, 2 = single off
  localparam logic [2:0] VEC [6] = '{3'b101, 3'b010, 3'b000, 3'b101, 3'b100, 3'b010};

  logic clk = 1'b0, rst_n = 1'b0, hs_cmd = 1'b0, ls_cmd = 1'b0, supply_ok = 1'b1;
  logic on_pulse, off_pulse, ls_gate;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  level_shift_encoder #(.PULSE_W(PW), .GAP_W(GW), .START_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .hs_cmd(hs_cmd), .ls_cmd(ls_cmd),
    .supply_ok(supply_ok), .on_pulse(on_pulse), .off_pulse(off_pulse),
    .ls_gate(ls_gate)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_seq(input int s, input int kind, input int from, input string req);
    int bad_i = 0, act = 0, exp = 0;
    bit both = 0;
    for (int i = 1; i <= s + 2 * PW + GW + 3; i++) begin
      bit eon, eoff;
      @(negedge clk);
      eon  = (kind == 1) && ((i >= s && i < s + PW) || (i >= s + PW + GW && i < s + 2 * PW + GW));
      eoff = (kind == 2) && (i >= s && i < s + PW);
      if (on_pulse && off_pulse) both = 1;
      if (i >= from && bad_i == 0 && (on_pulse != eon || off_pulse != eoff)) begin
        bad_i = i;
        act = {on_pulse, off_pulse};
        exp = {eon, eoff};
      end
    end
    chk(bad_i == 0, $sformatf("%s seq at cycle %0d {on,off}", req, bad_i), act, exp);
    chk(!both, "R3 channels both high", int'(both), 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ls_cmd = 1'b1;
    repeat (3) @(negedge clk);
    chk({on_pulse, off_pulse, ls_gate} == 3'b000, "R8 reset outputs", {on_pulse, off_pulse, ls_gate}, 0);
    ls_cmd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check_seq(1, 2, 1, "R6 after reset, low level");

    foreach (VEC[v]) begin
      hs_cmd = VEC[v][2];
      check_seq(LAT, int'(VEC[v][1:0]), 1,
                VEC[v][1:0] == 2'd1 ? "R1" : (VEC[v][1:0] == 2'd2 ? "R2" : "R9"));
    end

    // R7: matched latency with a simultaneous high-side edge
    hs_cmd = 1'b1; ls_cmd = 1'b1;
    for (int i = 1; i <= LAT; i++) begin
      @(negedge clk);
      chk(ls_gate == (i >= LAT), $sformatf("R7 ls_gate cycle %0d", i), ls_gate, i >= LAT);
      chk(on_pulse == (i >= LAT), $sformatf("R7 matched on_pulse cycle %0d", i), on_pulse, i >= LAT);
    end
    repeat (2 * PW + GW + 2) @(negedge clk);
    ls_cmd = 1'b0;
    check_seq(LAT, 0, 1, "R7 ls change leaves channels idle");
    chk(ls_gate == 1'b0, "R7 ls_gate released", ls_gate, 0);

    // R4: abort an off pulse with a rising edge
    hs_cmd = 1'b0;
    repeat (3) @(negedge clk);
    hs_cmd = 1'b1;
    check_seq(LAT, 1, LAT, "R4 off aborted by rise");
    // R4: abort an on pair inside its gap with a falling edge
    hs_cmd = 1'b0;
    repeat (2 * PW + GW + 4) @(negedge clk);
    hs_cmd = 1'b1;
    repeat (LAT + PW + 1) @(negedge clk);
    hs_cmd = 1'b0;
    check_seq(LAT, 2, 1, "R4 on pair aborted in gap");

    // R5 / R6: supply loss and recovery
    ls_cmd = 1'b1;
    hs_cmd = 1'b1;
    repeat (LAT) @(negedge clk);
    chk(on_pulse && ls_gate, "R5 precondition active", {on_pulse, ls_gate}, 3);
    supply_ok = 1'b0;
    #1;
    chk({on_pulse, off_pulse, ls_gate} == 3'b000, "R5 immediate force", {on_pulse, off_pulse, ls_gate}, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      hs_cmd = i[0];
      #1;
      chk({on_pulse, off_pulse, ls_gate} == 3'b000, "R5 held while low", {on_pulse, off_pulse, ls_gate}, 0);
    end
    hs_cmd = 1'b1;
    repeat (LAT + 2) @(negedge clk);
    supply_ok = 1'b1;
    check_seq(1, 1, 1, "R6 recover high level");
    supply_ok = 1'b0;
    hs_cmd = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    supply_ok = 1'b1;
    check_seq(1, 2, 1, "R6 recover low level");

    // R8: reset in the middle of an on pair
    hs_cmd = 1'b1;
    repeat (LAT) @(negedge clk);
    chk(on_pulse, "R8 precondition on", on_pulse, 1);
    rst_n = 1'b0; hs_cmd = 1'b0;
    #1;
    chk({on_pulse, off_pulse, ls_gate} == 3'b000, "R8 async clear", {on_pulse, off_pulse, ls_gate}, 0);
    repeat (3) @(negedge clk);
    chk({on_pulse, off_pulse, ls_gate} == 3'b000, "R8 held in reset", {on_pulse, off_pulse, ls_gate}, 0);
    rst_n = 1'b1;
    check_seq(1, 2, 1, "R8 sequence cleared, resync after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule